// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave (128 x 8)

This block is a slave for a two-wire serial memory. It sits behind an open-drain bus and holds a 128-byte array built from flip-flops. The block samples the clock line and data line with the system clock and recognises start and stop conditions. It matches a 7-bit device address: a fixed four-bit family code followed by three select inputs. It then serves byte writes, page writes, current-address reads, sequential reads, and random reads. A random read is a write of the word address, then a repeated start, then a read. The block only pulls the data line low. The `sda_oe` output, when high, means "drive the line to 0".

One internal address pointer is shared by reads and writes, and it survives from one transaction to the next. The pointer advances differently in each direction:
- After each byte a read returns, the whole 7-bit pointer advances by one.
- After each byte a write stores, only the low three bits advance. Writes therefore wrap inside an 8-byte page.

The bus itself is the only data interface. Its timing is paced by the master, so the block has no valid/ready stream. The select inputs are plain static control pins.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and the address pointer is 0. Reset does not clear the array contents, so a current-address read straight after reset returns the byte stored at address 0.
- R2: After a start, the first byte is compared with `{4'b1010, dev_sel[2:0], rw}` (MSB first, rw=1 for read). On a match the slave acknowledges. On a mismatch it does not acknowledge, and it ignores the bus, including the acknowledge slots and any array writes, until the next start.
- R3: In a write transaction, the byte after the device address is the word address, and its low 7 bits load the pointer. Every later byte is stored at the pointer. Each of these bytes is acknowledged.
- R4: After each stored byte, pointer bits [6:3] stay unchanged and bits [2:0] increment modulo 8.
- R5: A read transaction with no word address returns the byte at the pointer, MSB first, one bit per SCL clock.
- R6: After the 8th bit of each read byte, the full 7-bit pointer increments, wrapping from 127 to 0. If the master acknowledges, the next byte follows.
- R7: If the master does not acknowledge a read byte, the slave releases SDA and stays idle. It then responds only after a new start.
- R8: The pointer keeps its value (last accessed address plus one, by the rule of R4 or R6) from one transaction to the next.
- R9: A repeated start after the word address, followed by a matching read address, returns the byte at that word address.
- R10: `sda_oe` changes only while SCL is low. During an acknowledge it stays high for the whole high phase of the 9th clock.
- R11: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop at any point, even mid-byte, returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND with the slave drive) |
| dev_sel | input | 3 | Device select bits compared with the address byte |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The checker runs every cycle. It confirms that the drive enable moves only while the synchronised clock is low and that an acknowledge covers the whole 9th high phase. It also confirms that each array write advances only the low three pointer bits, that each completed read byte advances the full pointer, and that the slave is idle with SDA released after a stop.

Some behaviours can only be shown by the bench's bus-master scenarios. These are the correctness of the stored and returned data and address matching against the select pins. They also include the pointer carrying over between transactions, the 127-to-0 wrap during a sequential read, random reads through a repeated start, and recovery after an aborted byte.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RX    = 3'd1,
    ST_RXACK = 3'd2,
    ST_TX    = 3'd3,
    ST_TXACK = 3'd4
  } st_t;

  typedef enum logic [1:0] {
    K_DEV   = 2'd0,
    K_WADDR = 2'd1,
    K_WDATA = 2'd2
  } kind_t;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= '1;
      prev <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      prev <= pipe[STAGES-1];
    end
  end

  assign level = pipe[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int          AW       = 7,
  parameter int          PW       = 3,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [2:0]        dev_sel,
  input  logic [BYTE_W-1:0] rdata,
  output logic              mem_we,
  output logic [BYTE_W-1:0] wdata,
  output logic [AW-1:0]     addr_o,
  output st_t               state_o,
  output logic              stop_o,
  output logic              sda_oe
);
  localparam int CW = $clog2(BYTE_W + 1);

  st_t               state;
  kind_t             kind;
  logic [CW-1:0]     bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic              rw;
  logic              mack;
  logic [AW-1:0]     addr;

  logic start_c, stop_c, byte_done, dev_hit;
  logic [AW-1:0] next_waddr;

  assign start_c    = sda_fall & scl_lvl;
  assign stop_c     = sda_rise & scl_lvl;
  assign byte_done  = scl_fall && (bitcnt == CW'(BYTE_W));
  assign dev_hit    = (shreg[BYTE_W-1:1] == {DEV_CODE, dev_sel});
  assign next_waddr = {addr[AW-1:PW], PW'(addr[PW-1:0] + 1'b1)};

  assign mem_we  = (state == ST_RX) && (kind == K_WDATA) && byte_done &&
                   !start_c && !stop_c;
  assign wdata   = shreg;
  assign addr_o  = addr;
  assign state_o = state;
  assign stop_o  = stop_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind   <= K_DEV;
      bitcnt <= '0;
      shreg  <= '0;
      txreg  <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      addr   <= '0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      state  <= ST_RX;
      kind   <= K_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            bitcnt <= '0;
            case (kind)
              K_DEV: begin
                if (dev_hit) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_RXACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              K_WADDR: begin
                addr   <= shreg[AW-1:0];
                sda_oe <= 1'b1;
                state  <= ST_RXACK;
              end
              default: begin
                addr   <= next_waddr;
                sda_oe <= 1'b1;
                state  <= ST_RXACK;
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (kind == K_DEV && rw) begin
              txreg  <= rdata;
              sda_oe <= ~rdata[BYTE_W-1];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              kind   <= (kind == K_DEV) ? K_WADDR : K_WDATA;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            sda_oe <= 1'b0;
            addr   <= addr + 1'b1;
            state  <= ST_TXACK;
          end else if (scl_fall) begin
            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
            sda_oe <= ~txreg[BYTE_W-2];
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            mack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack) begin
              bitcnt <= '0;
              txreg  <= rdata;
              sda_oe <= ~rdata[BYTE_W-1];
              state  <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eep_pkg::*;
#(
  parameter int         AW          = 7,
  parameter int         PW          = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel,
  output logic       sda_oe
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, lvl, rise, fall;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw[g]),
      .level (lvl[g]),
      .rise  (rise[g]),
      .fall  (fall[g])
    );
  end

  logic              scl_lvl;
  logic              mem_we;
  logic              stop_evt;
  logic [BYTE_W-1:0] wdata, rdata;
  logic [AW-1:0]     addr;
  st_t               state;

  assign scl_lvl = lvl[0];

  eep_ctrl #(.AW(AW), .PW(PW), .DEV_CODE(DEV_CODE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .scl_rise (rise[0]),
    .scl_fall (fall[0]),
    .sda_lvl  (lvl[1]),
    .sda_rise (rise[1]),
    .sda_fall (fall[1]),
    .dev_sel  (dev_sel),
    .rdata    (rdata),
    .mem_we   (mem_we),
    .wdata    (wdata),
    .addr_o   (addr),
    .state_o  (state),
    .stop_o   (stop_evt),
    .sda_oe   (sda_oe)
  );

  eep_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );
endmodule

// File: rtl/eep_chk.sv
module eep_chk
  import eep_pkg::*;
#(
  parameter int AW = 7,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          sda_oe,
  input logic          mem_we,
  input logic          stop_evt,
  input logic [AW-1:0] addr,
  input st_t           state
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl)); // R10

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RXACK && scl_lvl) |-> sda_oe); // R10

  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr[AW-1:PW] == $past(addr[AW-1:PW])) &&
               (addr[PW-1:0] == PW'($past(addr[PW-1:0]) + 1'b1))); // R4

  AST_READ_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TXACK && $past(state) == ST_TX) |->
      (addr == AW'($past(addr) + 1'b1))); // R6

  AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R7

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_evt) |-> (state == ST_IDLE && !sda_oe)); // R11
endmodule

bind i2c_eeprom_slave eep_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_lvl  (scl_lvl),
  .sda_oe   (sda_oe),
  .mem_we   (mem_we),
  .stop_evt (stop_evt),
  .addr     (addr),
  .state    (state)
);

// File: tb/sim_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_slave;
  localparam logic [2:0] SEL   = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};
  localparam int         H     = 6;
  localparam int         NVEC  = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h00, 8'h5A}, {8'h01, 8'hC3}, {8'h1A, 8'h77},
    {8'h7F, 8'hE1}, {8'h40, 8'h0F}, {8'h33, 8'hA5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int   checks = 0;
  int   failures = 0;
  int   viol = 0;
  bit   done = 1'b0;
  logic prev_oe = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_eeprom_slave u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_bus),
    .dev_sel (SEL),
    .sda_oe  (sda_oe)
  );

  // R10 monitor: drive enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe !== prev_oe && scl) viol++;
      prev_oe = sda_oe;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b;
    waitc(H);
    scl = 1'b1;
    waitc(H);
    s = sda_bus;
    waitc(H);
    scl = 1'b0;
    waitc(H);
  endtask

  task automatic bus_start();
    m_sda = 1'b1;
    waitc(H);
    scl = 1'b1;
    waitc(H);
    m_sda = 1'b0;
    waitc(H);
    scl = 1'b0;
    waitc(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0;
    waitc(H);
    scl = 1'b1;
    waitc(H);
    m_sda = 1'b1;
    waitc(2 * H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ackd = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~give_ack, s);
    m_sda = 1'b1;
  endtask

  task automatic byte_write(input logic [7:0] a, input logic [7:0] d);
    logic ak;
    bus_start();
    send_byte(DEV_W, ak); chk("R2 write address ack", {7'd0, ak}, 8'd1);
    send_byte(a, ak);     chk("R3 word address ack", {7'd0, ak}, 8'd1);
    send_byte(d, ak);     chk("R3 data ack", {7'd0, ak}, 8'd1);
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
    logic ak;
    bus_start();
    send_byte(DEV_W, ak);
    send_byte(a, ak);
    bus_start();
    send_byte(DEV_R, ak); chk("R9 read address ack", {7'd0, ak}, 8'd1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic cur_read(output logic [7:0] d);
    logic ak;
    bus_start();
    send_byte(DEV_R, ak); chk("R5 read address ack", {7'd0, ak}, 8'd1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       ak;
    logic       s;

    do_reset();
    chk("R1 sda released after reset", {7'd0, sda_oe}, 8'd0);

    // Table: byte writes, then random reads back
    for (int i = 0; i < NVEC; i++) byte_write(VEC[i][15:8], VEC[i][7:0]);
    for (int i = 0; i < NVEC; i++) begin
      rand_read(VEC[i][15:8], d);
      chk("R9 random read data", d, VEC[i][7:0]);
    end

    // R4: page write from 0x1E wraps to 0x18
    bus_start();
    send_byte(DEV_W, ak);
    send_byte(8'h1E, ak);
    send_byte(8'h11, ak); chk("R3 page byte ack", {7'd0, ak}, 8'd1);
    send_byte(8'h22, ak);
    send_byte(8'h33, ak);
    send_byte(8'h44, ak);
    bus_stop();
    // R8: pointer now 0x1A -> current read returns 0x77
    cur_read(d);
    chk("R8 pointer kept after write", d, 8'h77);
    rand_read(8'h1E, d); chk("R4 page byte at 0x1E", d, 8'h11);
    rand_read(8'h1F, d); chk("R4 page byte at 0x1F", d, 8'h22);
    rand_read(8'h18, d); chk("R4 wrapped byte at 0x18", d, 8'h33);
    rand_read(8'h19, d); chk("R4 wrapped byte at 0x19", d, 8'h44);

    // R6: sequential read 127 -> 0, then NACK (R7)
    bus_start();
    send_byte(DEV_W, ak);
    send_byte(8'h7F, ak);
    bus_start();
    send_byte(DEV_R, ak);
    recv_byte(1'b1, d); chk("R6 seq byte at 127", d, 8'hE1);
    recv_byte(1'b0, d); chk("R6 wrap to address 0", d, 8'h5A);
    waitc(H);
    chk("R7 released after nack", {7'd0, sda_oe}, 8'd0);
    // R7: while idle after NACK, a byte clocked in gets no ack
    send_byte(DEV_W, ak); chk("R7 ignored until start", {7'd0, ak}, 8'd0);
    bus_stop();
    cur_read(d);
    chk("R8 pointer kept after read", d, 8'hC3);

    // R2: mismatching select is ignored, no write happens
    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, ak); chk("R2 mismatch not acked", {7'd0, ak}, 8'd0);
    send_byte(8'h01, ak); chk("R2 later byte not acked", {7'd0, ak}, 8'd0);
    send_byte(8'h00, ak); chk("R2 data byte not acked", {7'd0, ak}, 8'd0);
    bus_stop();
    rand_read(8'h01, d); chk("R2 cell unchanged", d, 8'hC3);

    // R11: stop in the middle of a byte
    bus_start();
    for (int i = 7; i >= 4; i--) clk_bit(DEV_W[i], s);
    bus_stop();
    chk("R11 released after stop", {7'd0, sda_oe}, 8'd0);
    rand_read(8'h33, d); chk("R11 recovery read", d, 8'hA5);

    // R1: reset clears pointer but not array
    do_reset();
    chk("R1 sda released after second reset", {7'd0, sda_oe}, 8'd0);
    cur_read(d);
    chk("R1 pointer zero after reset", d, 8'h5A);

    chk("R10 drive changes only with SCL low", viol[7:0], 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule